// File: doc/BRIEF.md
# Potentiometer Wiper Control Slave (Two-Wire Serial Bus)

This block is the serial-bus slave that sets the tap of a single-channel digital potentiometer. It watches a standard two-wire serial bus (clock and data lines, open-drain) as sampled in the system clock domain. It recognises its own identification byte and a register address byte. It then commits a single data byte to one of two 8-bit registers, or returns the addressed register's value after a repeated START. The current 7-bit tap code and the shutdown state go straight to the analog tap-select logic.

Both bus lines pass through a two-flop synchronizer and a persistence filter before the protocol engine sees them. The filter has a parameterised length, so bus glitches shorter than the filter window have no effect. Its length is chosen from the system clock period so that it covers about 50 ns. The slave never holds the clock line low. It controls the data line only through an open-drain pull-down enable.

The identification byte is `10100` in bits 7..3, the two strap pins in bits 2..1, and the read/write flag in bit 0. The tap register is at address 0x00. The control register is at 0x10, and its bit 6 selects normal operation (1) or shutdown (0).

Top module: `pot_i2c_regif`

## Requirements
- R1: After reset the tap code is 64 (0x40), shutdown is inactive (control bit 6 = 1) and the SDA pull-down is released.
- R2: The slave pulls SDA low in the ninth clock of an identification byte only when bits 7..3 are 10100 and bits 2..1 equal the strap pins. On a mismatch it never drives SDA and ignores every byte until the next START.
- R3: A write is START, identification byte with bit 0 = 0, address 0x00, data byte. It replaces the tap code with data bits 6..0 (bit 7 is dropped). The change appears on the rising SCL edge of the ninth clock of the data byte and not before.
- R4: A write to address 0x10 sets the shutdown state from data bit 6 (0 = shutdown active, 1 = normal). Reading 0x10 returns only bit 6, with all other bits 0. The tap code is kept through shutdown.
- R5: An address byte other than 0x00 or 0x10 is not acknowledged. A following data byte is not acknowledged either, and neither register changes.
- R6: A read is a write-mode identification byte, an address byte, a repeated START, and a read-mode identification byte. The slave then sends the register MSB first, changing SDA only after SCL falls. The tap register reads with bit 7 = 0. A read-mode identification byte with no address phase since the last STOP is not acknowledged.
- R7: While the master acknowledges, each further read byte repeats the same register value. A master NACK ends the transfer and releases SDA.
- R8: A STOP at any point returns the slave to idle, releases SDA and forgets the register pointer. A data byte cut short by STOP writes nothing.
- R9: A pulse on SCL or SDA lasting fewer than FILTER_CYCLES system clocks does not change the protocol state, including a false START or STOP while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| sclIn | input | 1 | Sampled bus clock line |
| sdaIn | input | 1 | Sampled bus data line |
| addrPins | input | 2 | Strap pins compared with identification bits 2..1 |
| sdaDrive | output | 1 | 1 pulls the data line low (open-drain enable) |
| wiperCode | output | 7 | Current tap code for the resistor array |
| shutdownActive | output | 1 | 1 when the potentiometer is in shutdown |

## Verification
The assertions take for granted that SDA from the master changes only while SCL is low, except at START and STOP. They also assume that real bus edges are at least FILTER_CYCLES system clocks apart, so that the filtered lines keep the order of the raw edges. The stimulus uses a three-cycle filter and twelve-cycle half periods. The master moves SDA two cycles after each SCL fall. The only sub-window pulses it produces are the deliberate glitches of the R9 test.

// File: rtl/pot_regif_pkg.sv
package pot_regif_pkg;
  localparam int WIPER_BITS = 7;
  localparam int CTRL_BIT = 6;
  localparam logic [4:0] ID_PREFIX = 5'b10100;
  localparam logic [7:0] ADDR_TAP = 8'h00;
  localparam logic [7:0] ADDR_CTRL = 8'h10;
  localparam logic [7:0] RESET_VALUE = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_WDATA, ST_RDATA, ST_SKIP
  } state_t;

  // strobes from control to datapath, each one system cycle wide
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic commit;
    logic loadTx;
    logic shiftTx;
  } strobe_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILTER_CYCLES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = (FILTER_CYCLES > 2) ? $clog2(FILTER_CYCLES) : 1;

  logic syncA, syncQ;
  logic [CNT_W-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncQ <= 1'b1;
      cleanOut <= 1'b1;
      runLen <= '0;
    end else begin
      syncA <= rawIn;
      syncQ <= syncA;
      if (syncQ != cleanOut) begin
        if (runLen == CNT_W'(FILTER_CYCLES - 1)) begin
          cleanOut <= syncQ;
          runLen <= '0;
        end else begin
          runLen <= runLen + 1'b1;
        end
      end else begin
        runLen <= '0;
      end
    end
  end

  // R9: an output change needs the synchronized input to have held the new level
  assert_filter_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cleanOut != $past(cleanOut)) |-> ($past(syncQ) == cleanOut && $past(syncQ, 2) == cleanOut));
endmodule

// File: rtl/pot_i2c_datapath.sv
module pot_i2c_datapath
  import pot_regif_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobe_t stb,
  input  logic sdaF,
  input  logic ackLow,
  input  logic txOn,
  output logic [7:0] rxByte,
  output logic [WIPER_BITS-1:0] wiperCode,
  output logic shutdownActive,
  output logic sdaDrive
);
  logic [7:0] rxShift, txShift, readValue;
  logic [WIPER_BITS-1:0] tapReg;
  logic runBit, ptrCtrl;

  always_comb begin
    readValue = '0;
    if (ptrCtrl) readValue[CTRL_BIT] = runBit;
    else readValue[WIPER_BITS-1:0] = tapReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      tapReg <= RESET_VALUE[WIPER_BITS-1:0];
      runBit <= RESET_VALUE[CTRL_BIT];
      ptrCtrl <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaF};
      if (stb.setPtr) ptrCtrl <= (rxShift == ADDR_CTRL);
      if (stb.commit) begin
        if (ptrCtrl) runBit <= rxShift[CTRL_BIT];
        else tapReg <= rxShift[WIPER_BITS-1:0];
      end
      if (stb.loadTx) txShift <= readValue;
      else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign rxByte = rxShift;
  assign wiperCode = tapReg;
  assign shutdownActive = ~runBit;
  assign sdaDrive = ackLow | (txOn & ~txShift[7]);

  // R3: tap code only moves on a commit strobe
  assert_tap_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(tapReg));
  // R4: shutdown state only moves on a commit strobe
  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(runBit));
  // R6: acknowledge and data transmit never overlap
  assert_drive_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ackLow && txOn));
endmodule

// File: rtl/pot_i2c_ctrl.sv
module pot_i2c_ctrl
  import pot_regif_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclF,
  input  logic sdaF,
  input  logic [1:0] addrPins,
  input  logic [7:0] rxByte,
  output strobe_t stb,
  output logic ackLow,
  output logic txOn
);
  logic sclQ, sdaQ, ptrValid, masterAck;
  logic [3:0] bitCnt;
  state_t state, afterAck;

  wire sclRise = sclF & ~sclQ;
  wire sclFall = ~sclF & sclQ;
  wire startDet = sclF & sclQ & sdaQ & ~sdaF;
  wire stopDet = sclF & sclQ & ~sdaQ & sdaF;
  wire idMatch = (rxByte[7:3] == ID_PREFIX) && (rxByte[2:1] == addrPins);
  wire addrOk = (rxByte == ADDR_TAP) || (rxByte == ADDR_CTRL);
  wire rxPhase = (state == ST_ID) || (state == ST_ADDR) || (state == ST_WDATA);

  always_comb begin
    stb = '0;
    stb.shiftIn = sclRise && rxPhase && (bitCnt < 4'd8);
    stb.commit = sclRise && (state == ST_WDATA) && (bitCnt == 4'd8);
    stb.setPtr = sclFall && (state == ST_ADDR) && (bitCnt == 4'd8) && addrOk;
    stb.shiftTx = sclFall && (state == ST_RDATA) && (bitCnt != 4'd0) && (bitCnt < 4'd8);
    stb.loadTx = sclFall && (bitCnt == 4'd9) &&
                 (((state == ST_RDATA) && masterAck) ||
                  ((state == ST_ID) && (afterAck == ST_RDATA)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
      state <= ST_IDLE;
      afterAck <= ST_SKIP;
      bitCnt <= '0;
      ptrValid <= 1'b0;
      masterAck <= 1'b0;
      ackLow <= 1'b0;
      txOn <= 1'b0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (startDet) begin
        state <= ST_ID;
        bitCnt <= '0;
        ackLow <= 1'b0;
        txOn <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        bitCnt <= '0;
        ackLow <= 1'b0;
        txOn <= 1'b0;
        ptrValid <= 1'b0;
      end else if (state != ST_IDLE && state != ST_SKIP) begin
        if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 4'd8 && state == ST_RDATA) masterAck <= ~sdaF;
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            case (state)
              ST_ID:
                if (idMatch && (!rxByte[0] || ptrValid)) begin
                  ackLow <= 1'b1;
                  afterAck <= rxByte[0] ? ST_RDATA : ST_ADDR;
                end else begin
                  state <= ST_SKIP;
                end
              ST_ADDR:
                if (addrOk) begin
                  ackLow <= 1'b1;
                  ptrValid <= 1'b1;
                  afterAck <= ST_WDATA;
                end else begin
                  state <= ST_SKIP;
                end
              ST_WDATA: begin
                ackLow <= 1'b1;
                afterAck <= ST_SKIP;
              end
              default: txOn <= 1'b0;
            endcase
          end else if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            ackLow <= 1'b0;
            if (state == ST_RDATA) begin
              if (masterAck) txOn <= 1'b1;
              else state <= ST_SKIP;
            end else begin
              state <= afterAck;
              txOn <= (afterAck == ST_RDATA);
            end
          end
        end
      end
    end
  end

  // R8: a STOP leaves the line released and the engine idle
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!ackLow && !txOn && state == ST_IDLE));
  // R2: an ignored transfer never touches SDA
  assert_skip_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> (!ackLow && !txOn));
  // R5: a commit only follows an accepted address
  assert_commit_ptr_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> ptrValid);
  // R3: datapath strobes are mutually exclusive
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.setPtr, stb.commit, stb.loadTx, stb.shiftTx}));
endmodule

// File: rtl/pot_i2c_regif.sv
module pot_i2c_regif
  import pot_regif_pkg::*;
#(
  parameter int FILTER_CYCLES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic [1:0] addrPins,
  output logic sdaDrive,
  output logic [WIPER_BITS-1:0] wiperCode,
  output logic shutdownActive
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines, cleanLines;
  logic sclF, sdaF, ackLow, txOn;
  logic [7:0] rxByte;
  strobe_t stb;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    line_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end

  assign sclF = cleanLines[1];
  assign sdaF = cleanLines[0];

  pot_i2c_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF), .addrPins(addrPins),
    .rxByte(rxByte), .stb(stb), .ackLow(ackLow), .txOn(txOn)
  );

  pot_i2c_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaF(sdaF), .ackLow(ackLow), .txOn(txOn),
    .rxByte(rxByte), .wiperCode(wiperCode), .shutdownActive(shutdownActive),
    .sdaDrive(sdaDrive)
  );
endmodule

// File: tb/sim_pot_i2c_regif.sv
`timescale 1ns/1ps
module sim_pot_i2c_regif;
  localparam int FILT = 3;
  localparam int HALF = 12;
  localparam logic [1:0] PINS = 2'b10;
  localparam logic [7:0] ID_W = {5'b10100, PINS, 1'b0};
  localparam logic [7:0] ID_R = {5'b10100, PINS, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDrive, shutdownActive;
  logic [6:0] wiperCode;
  wire sdaBus = sdaM & ~sdaDrive;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pot_i2c_regif #(.FILTER_CYCLES(FILT)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrPins(PINS),
    .sdaDrive(sdaDrive), .wiperCode(wiperCode), .shutdownActive(shutdownActive)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic startCond();
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b0; tick(2);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0; tick(2);
  endtask

  task automatic ackBit(output logic ack);
    sdaM = 1'b1; tick(HALF);
    sclM = 1'b1; tick(HALF / 2);
    ack = ~sdaBus; tick(HALF / 2);
    sclM = 1'b0; tick(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    ackBit(ack);
  endtask

  task automatic recvByte(output logic [7:0] b, input logic giveAck);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      sclM = 1'b1; tick(HALF / 2);
      b[i] = sdaBus; tick(HALF / 2);
      sclM = 1'b0; tick(2);
    end
    sdaM = ~giveAck; tick(HALF);
    sclM = 1'b1; tick(HALF);
    sclM = 1'b0; tick(2);
    sdaM = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d,
                          output logic aId, output logic aAd, output logic aDa);
    startCond();
    sendByte(ID_W, aId);
    sendByte(a, aAd);
    sendByte(d, aDa);
    stopCond();
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] v, output logic ok);
    logic k1, k2, k3;
    v = 8'hxx;
    startCond();
    sendByte(ID_W, k1);
    sendByte(a, k2);
    k3 = 1'b0;
    if (k1 && k2) begin
      startCond();
      sendByte(ID_R, k3);
      if (k3) recvByte(v, 1'b0);
    end
    stopCond();
    ok = k1 & k2 & k3;
  endtask

  initial begin
    logic a1, a2, a3, ok;
    logic [7:0] v, b1, b2, b3;
    int expW, expS;
    tick(10);
    // R1 reset state
    check("R1 tap at reset", wiperCode, 64);
    check("R1 shutdown at reset", shutdownActive, 0);
    check("R1 sda released", sdaDrive, 0);
    rstN = 1'b1;
    tick(10);
    check("R1 tap after reset release", wiperCode, 64);

    // R2 strap field sweep and prefix mismatch
    for (int f = 0; f < 4; f++) begin
      startCond();
      sendByte({5'b10100, 2'(f), 1'b0}, a1);
      check("R2 id ack vs strap", a1, (2'(f) == PINS) ? 1 : 0);
      sendByte(8'h00, a2);
      if (2'(f) != PINS) begin
        check("R2 ignored after mismatch", a2, 0);
        sendByte(8'h11, a3);
        check("R2 data ignored", a3, 0);
      end
      stopCond();
      check("R2 tap unchanged", wiperCode, 64);
    end
    startCond();
    sendByte({5'b10110, PINS, 1'b0}, a1);
    check("R2 prefix mismatch nack", a1, 0);
    stopCond();

    // R3 commit on the ninth clock of the data byte
    startCond();
    sendByte(ID_W, a1);
    sendByte(8'h00, a2);
    for (int i = 7; i >= 0; i--) sendBit(8'h95 >> i);
    sdaM = 1'b1; tick(HALF);
    check("R3 no change before ninth clock", wiperCode, 64);
    check("R3 data ack driven", sdaBus, 0);
    sclM = 1'b1; tick(HALF);
    check("R3 change on ninth clock, bit7 dropped", wiperCode, 8'h15);
    sclM = 1'b0; tick(2);
    stopCond();
    check("R8 sda released after stop", sdaDrive, 0);

    // R3/R6 tap sweep with read-back
    for (int d = 0; d < 256; d += 9) begin
      writeReg(8'h00, 8'(d), a1, a2, a3);
      check("R3 write acks", {a1, a2, a3}, 7);
      check("R3 tap code", wiperCode, d & 127);
      readReg(8'h00, v, ok);
      check("R6 read ok", ok, 1);
      check("R6 tap read-back", v, d & 127);
    end

    // R4 control register
    writeReg(8'h00, 8'h2C, a1, a2, a3);
    writeReg(8'h10, 8'h00, a1, a2, a3);
    check("R4 shutdown on", shutdownActive, 1);
    check("R4 tap kept", wiperCode, 8'h2C);
    readReg(8'h10, v, ok);
    check("R4 read zero", v, 0);
    writeReg(8'h10, 8'hBF, a1, a2, a3);
    check("R4 bit6 clear keeps shutdown", shutdownActive, 1);
    readReg(8'h10, v, ok);
    check("R4 other bits read 0", v, 0);
    writeReg(8'h10, 8'hFF, a1, a2, a3);
    check("R4 shutdown off", shutdownActive, 0);
    readReg(8'h10, v, ok);
    check("R4 read bit6 only", v, 8'h40);
    check("R4 tap restored", wiperCode, 8'h2C);

    // R5 address sweep
    writeReg(8'h00, 8'h05, a1, a2, a3);
    writeReg(8'h10, 8'h00, a1, a2, a3);
    expW = 5; expS = 1;
    for (int a = 0; a < 256; a += 8) begin
      writeReg(8'(a), 8'h73, a1, a2, a3);
      check("R5 address ack", a2, (a == 0 || a == 16) ? 1 : 0);
      if (a == 0) expW = 8'h73;
      if (a == 16) expS = 0;
      if (a != 0 && a != 16) check("R5 data nack", a3, 0);
      check("R5 tap value", wiperCode, expW);
      check("R5 shutdown value", shutdownActive, expS);
    end
    readReg(8'h20, v, ok);
    check("R5 read of bad address refused", ok, 0);

    // R7 multi-byte read repeats
    writeReg(8'h00, 8'h5A, a1, a2, a3);
    startCond();
    sendByte(ID_W, a1);
    sendByte(8'h00, a2);
    startCond();
    sendByte(ID_R, a3);
    recvByte(b1, 1'b1);
    recvByte(b2, 1'b1);
    recvByte(b3, 1'b0);
    check("R7 byte 1", b1, 8'h5A);
    check("R7 byte 2", b2, 8'h5A);
    check("R7 byte 3", b3, 8'h5A);
    tick(HALF);
    check("R7 released after nack", sdaDrive, 0);
    stopCond();

    // R8 stop forgets pointer; truncated data byte writes nothing
    startCond();
    sendByte(ID_W, a1);
    sendByte(8'h00, a2);
    stopCond();
    startCond();
    sendByte(ID_R, a3);
    check("R6 read without address refused", a3, 0);
    stopCond();
    startCond();
    sendByte(ID_W, a1);
    sendByte(8'h00, a2);
    for (int i = 7; i >= 4; i--) sendBit(8'h11 >> i);
    stopCond();
    check("R8 truncated write ignored", wiperCode, 8'h5A);
    readReg(8'h00, v, ok);
    check("R8 bus usable after stop", v, 8'h5A);

    // R9 glitches on both lines inside a data byte
    startCond();
    sendByte(ID_W, a1);
    sendByte(8'h00, a2);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'(8'hA5 >> i);
      tick(4); sclM = 1'b1; tick(2); sclM = 1'b0; tick(HALF - 6);
      sclM = 1'b1; tick(4);
      sdaM = ~sdaM; tick(2); sdaM = ~sdaM;
      tick(HALF - 6);
      sclM = 1'b0; tick(2);
    end
    ackBit(a3);
    check("R9 data acked despite glitches", a3, 1);
    stopCond();
    check("R9 tap after glitches", wiperCode, 8'h25);
    readReg(8'h00, v, ok);
    check("R9 read after glitches", v, 8'h25);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule